// File: doc/BRIEF.md
# Super I/O Configuration Gate

This block is the configuration front end of a multi-function I/O controller. A host reaches it through a byte-wide I/O bus at two neighbouring addresses. The lower address is an index port and the upper one is a data port. Every configuration register stays hidden until the host writes a fixed entry key to the index port twice in a row. A separate exit value hides the registers again.

While the gate is open, the host first writes a register index to the index port. It then reads or writes that register through the data port. A logical-device select register picks which device bank the per-device registers reach. Each bank holds an enable bit, a 16-bit base address, an IRQ number and an IRQ type, and these drive the device-side outputs. A small block of global byte registers is shared by all banks.

Register values survive a lock and a later unlock. Only reset clears them.

Top module: `sio_cfg_gate`

## Requirements
- R1: The index port sits at address `BASE_ADDR` and the data port at `BASE_ADDR+1`. An access to any other address changes nothing and reads 0x00.
- R2: The gate opens (`cfg_open_o` high after the edge) only after 0x87 has been written to the index port at two consecutive index-port writes.
- R3: While the gate is locked, an index-port write of any value other than 0x87 clears the key progress. Data-port accesses leave the key progress unchanged.
- R4: While the gate is open, an index-port write of 0xAA locks it after that edge, and the value 0xAA is not kept as an index. Each lock clears the latched index to 0x00.
- R5: While the gate is locked, data-port writes are ignored, and reads of either port return 0xFF.
- R6: While the gate is open, an index-port read returns the last index written.
- R7: Index 0x07 holds the logical-device number and reads back its full byte. When the number is `NUM_DEV` or more, the bank registers read 0x00 and writes to them are ignored.
- R8: In the selected bank, bit 0 of index 0x30 is the device enable. It reads back as {7'b0, enable} and drives `dev_en_o[ldn]`.
- R9: In the selected bank, index 0x60 holds base-address bits 15:8 and index 0x61 holds bits 7:0. Both drive `dev_base_o[ldn*16 +: 16]`.
- R10: In the selected bank, index 0x70 holds the IRQ number and index 0x71 holds the IRQ type (0x02 means active high, edge triggered). Both read back and drive `dev_irq_o` and `dev_irq_type_o`.
- R11: After reset the gate is locked, the index and the logical-device number are 0x00, and every bank and global register is 0x00.
- R12: Indices 0x20 to 0x2F are global byte registers that can be read and written whatever the logical-device number is. Any other unimplemented index reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid_i | input | 1 | Bus access strobe for this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | I/O address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid during the read strobe |
| cfg_open_o | output | 1 | Gate open |
| dev_en_o | output | NUM_DEV | Per-device enable |
| dev_base_o | output | NUM_DEV*16 | Per-device base addresses |
| dev_irq_o | output | NUM_DEV*8 | Per-device IRQ numbers |
| dev_irq_type_o | output | NUM_DEV*8 | Per-device IRQ types |

## Verification
A write is captured at the clock edge that ends its strobe cycle. Its effects on `cfg_open_o`, the latched index and the device outputs are therefore due one edge later. The bench compares all outputs with its model at the falling edge after each access.

Read data is combinational, so it is due within the strobe cycle itself. The bench drives a read at a falling edge and samples `bus_rdata_o` one nanosecond later, before the capturing edge.

// File: rtl/sio_cfg_pkg.sv
// Shared constants and state type for the configuration gate.
// Assumes byte-wide register indices.
package sio_cfg_pkg;
    localparam logic [7:0] ENTRY_KEY    = 8'h87;
    localparam logic [7:0] EXIT_KEY     = 8'hAA;
    localparam logic [7:0] IDX_LDN      = 8'h07;
    localparam logic [7:0] IDX_ENABLE   = 8'h30;
    localparam logic [7:0] IDX_BASE_HI  = 8'h60;
    localparam logic [7:0] IDX_BASE_LO  = 8'h61;
    localparam logic [7:0] IDX_IRQ_NUM  = 8'h70;
    localparam logic [7:0] IDX_IRQ_TYPE = 8'h71;
    localparam logic [7:0] LOCKED_READ  = 8'hFF;

    typedef enum logic [1:0] {
        GATE_LOCKED = 2'd0,
        GATE_HALF   = 2'd1,
        GATE_OPEN   = 2'd2
    } gate_state_e;
endpackage

// File: rtl/sio_key_fsm.sv
// Entry/exit key tracker.
// Consumes qualified index-port writes and reports whether the gate is open.
// Assumes idx_wr_i is high for exactly one cycle per bus write.
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr_i,
    input  logic [7:0] wdata_i,
    output logic       open_o
);
    gate_state_e state_q;

    // Advance the key state on each index-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_LOCKED;
        end else if (idx_wr_i) begin
            case (state_q)
                GATE_LOCKED: state_q <= (wdata_i == ENTRY_KEY) ? GATE_HALF : GATE_LOCKED;
                GATE_HALF:   state_q <= (wdata_i == ENTRY_KEY) ? GATE_OPEN : GATE_LOCKED;
                GATE_OPEN:   state_q <= (wdata_i == EXIT_KEY)  ? GATE_LOCKED : GATE_OPEN;
                default:     state_q <= GATE_LOCKED;
            endcase
        end
    end

    assign open_o = (state_q == GATE_OPEN);

    // R2: the gate can only open right after an entry-key write.
    assert_open_after_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(idx_wr_i && wdata_i == ENTRY_KEY));

    // R3: a non-key write after the first key keeps the gate shut.
    assert_broken_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_HALF && idx_wr_i && wdata_i != ENTRY_KEY) |=> !open_o);

    // R4: the exit value closes the gate.
    assert_exit_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && idx_wr_i && wdata_i == EXIT_KEY) |=> !open_o);
endmodule

// File: rtl/sio_global_regs.sv
// Bank-independent global byte registers at indices GLOB_BASE..GLOB_BASE+NUM_GLOB-1.
// Assumes wr_en_i is already gated by the open state.
module sio_global_regs #(
    parameter int NUM_GLOB  = 16,
    parameter int GLOB_BASE = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [7:0] idx_i,
    input  logic [7:0] wdata_i,
    output logic       hit_o,
    output logic [7:0] rdata_o
);
    logic [7:0]          regs_q [NUM_GLOB];
    logic [NUM_GLOB-1:0] sel;

    // Decode the index into a one-hot register select.
    always_comb begin
        for (int i = 0; i < NUM_GLOB; i++) begin
            sel[i] = (idx_i == 8'(GLOB_BASE + i));
        end
    end

    // Store writes to the selected global register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_GLOB; i++) regs_q[i] <= 8'h00;
        end else if (wr_en_i) begin
            for (int i = 0; i < NUM_GLOB; i++) begin
                if (sel[i]) regs_q[i] <= wdata_i;
            end
        end
    end

    // Return the selected register, or zero when no register is selected.
    always_comb begin
        rdata_o = 8'h00;
        for (int i = 0; i < NUM_GLOB; i++) begin
            if (sel[i]) rdata_o = regs_q[i];
        end
    end

    assign hit_o = |sel;

    // R12: the decode never selects two registers.
    assert_glob_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: rtl/sio_dev_bank.sv
// One logical device's register bank: enable, base address, IRQ number, IRQ type.
// Assumes wr_en_i is high only when this bank is the selected one and the gate is open.
module sio_dev_bank
    import sio_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic [7:0]  idx_i,
    input  logic [7:0]  wdata_i,
    output logic [7:0]  rdata_o,
    output logic        en_o,
    output logic [15:0] base_o,
    output logic [7:0]  irq_o,
    output logic [7:0]  irq_type_o
);
    // Update the register addressed by the index on a bank write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o       <= 1'b0;
            base_o     <= 16'h0000;
            irq_o      <= 8'h00;
            irq_type_o <= 8'h00;
        end else if (wr_en_i) begin
            case (idx_i)
                IDX_ENABLE:   en_o         <= wdata_i[0];
                IDX_BASE_HI:  base_o[15:8] <= wdata_i;
                IDX_BASE_LO:  base_o[7:0]  <= wdata_i;
                IDX_IRQ_NUM:  irq_o        <= wdata_i;
                IDX_IRQ_TYPE: irq_type_o   <= wdata_i;
                default: ;
            endcase
        end
    end

    // Read back the register addressed by the index.
    always_comb begin
        case (idx_i)
            IDX_ENABLE:   rdata_o = {7'b0, en_o};
            IDX_BASE_HI:  rdata_o = base_o[15:8];
            IDX_BASE_LO:  rdata_o = base_o[7:0];
            IDX_IRQ_NUM:  rdata_o = irq_o;
            IDX_IRQ_TYPE: rdata_o = irq_type_o;
            default:      rdata_o = 8'h00;
        endcase
    end

    // R7: a bank that is not written keeps its contents.
    assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable({en_o, base_o, irq_o, irq_type_o}));
endmodule

// File: rtl/sio_cfg_gate.sv
// Configuration gate top: decodes the index and data ports, latches the index,
// holds the logical-device select and routes accesses to globals or a device bank.
// Assumes one bus access per strobe cycle. Read data is combinational.
module sio_cfg_gate
    import sio_cfg_pkg::*;
#(
    parameter int              NUM_DEV   = 4,
    parameter int              ADDR_W    = 12,
    parameter logic [11:0]     BASE_ADDR = 12'h370,
    parameter int              NUM_GLOB  = 16,
    parameter int              GLOB_BASE = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid_i,
    input  logic                  bus_write_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [7:0]            bus_wdata_i,
    output logic [7:0]            bus_rdata_o,
    output logic                  cfg_open_o,
    output logic [NUM_DEV-1:0]    dev_en_o,
    output logic [NUM_DEV*16-1:0] dev_base_o,
    output logic [NUM_DEV*8-1:0]  dev_irq_o,
    output logic [NUM_DEV*8-1:0]  dev_irq_type_o
);
    localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam logic [ADDR_W-1:0] IDX_PORT = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] DAT_PORT = ADDR_W'(BASE_ADDR + 12'd1);

    logic             hit_idx, hit_dat, idx_wr, dat_wr, open;
    logic [7:0]       idx_q, ldn_q;
    logic             ldn_valid;
    logic             glob_hit;
    logic [7:0]       glob_rd;
    logic [NUM_DEV-1:0] bank_wr;
    logic [7:0]       bank_rd [NUM_DEV];
    logic [7:0]       dat_rd;

    assign hit_idx = bus_valid_i && (bus_addr_i == IDX_PORT);
    assign hit_dat = bus_valid_i && (bus_addr_i == DAT_PORT);
    assign idx_wr  = hit_idx && bus_write_i;
    assign dat_wr  = hit_dat && bus_write_i && open;
    assign ldn_valid = (ldn_q < 8'(NUM_DEV));

    sio_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr_i (idx_wr),
        .wdata_i  (bus_wdata_i),
        .open_o   (open)
    );
    assign cfg_open_o = open;

    // Latch the index while open; clear it whenever the gate is shut.
    always_ff @(posedge clk) begin
        if (!rst_n || !open) begin
            idx_q <= 8'h00;
        end else if (idx_wr && bus_wdata_i != EXIT_KEY) begin
            idx_q <= bus_wdata_i;
        end
    end

    // Hold the logical-device select written through index 0x07.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldn_q <= 8'h00;
        end else if (dat_wr && idx_q == IDX_LDN) begin
            ldn_q <= bus_wdata_i;
        end
    end

    sio_global_regs #(
        .NUM_GLOB  (NUM_GLOB),
        .GLOB_BASE (GLOB_BASE)
    ) u_glob (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (dat_wr),
        .idx_i   (idx_q),
        .wdata_i (bus_wdata_i),
        .hit_o   (glob_hit),
        .rdata_o (glob_rd)
    );

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
        assign bank_wr[d] = dat_wr && (ldn_q == 8'(d));
        sio_dev_bank u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en_i    (bank_wr[d]),
            .idx_i      (idx_q),
            .wdata_i    (bus_wdata_i),
            .rdata_o    (bank_rd[d]),
            .en_o       (dev_en_o[d]),
            .base_o     (dev_base_o[d*16 +: 16]),
            .irq_o      (dev_irq_o[d*8 +: 8]),
            .irq_type_o (dev_irq_type_o[d*8 +: 8])
        );
    end

    // Select the data-port read source: LDN, globals, then the chosen bank.
    always_comb begin
        if (idx_q == IDX_LDN)   dat_rd = ldn_q;
        else if (glob_hit)      dat_rd = glob_rd;
        else if (ldn_valid)     dat_rd = bank_rd[ldn_q[SEL_W-1:0]];
        else                    dat_rd = 8'h00;
    end

    // Drive the bus read data for the port being read.
    always_comb begin
        bus_rdata_o = 8'h00;
        if (hit_idx && !bus_write_i)      bus_rdata_o = open ? idx_q : LOCKED_READ;
        else if (hit_dat && !bus_write_i) bus_rdata_o = open ? dat_rd : LOCKED_READ;
    end

    // R7: at most one bank receives a write.
    assert_one_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_wr));

    // R5: nothing changes through the data port while locked.
    assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !open |=> ($stable(dev_en_o) && $stable(dev_base_o) && $stable(ldn_q)));

    // R4: the latched index is zero whenever the gate has been shut for a cycle.
    assert_idx_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && !$rose(rst_n)) |=> (idx_q == 8'h00));
endmodule

// File: tb/sio_cfg_gate_tb.sv
`timescale 1ns/100ps
module sio_cfg_gate_tb_top;
    localparam int NDEV = 4;
    localparam int AW   = 12;
    localparam logic [11:0] IDXA = 12'h370;
    localparam logic [11:0] DATA = 12'h371;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid = 1'b0, wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic open_o;
    logic [NDEV-1:0] en_o;
    logic [NDEV*16-1:0] base_o;
    logic [NDEV*8-1:0] irq_o, irqt_o;

    int total = 0, bad = 0;
    bit finished = 0;

    // Reference model state.
    bit m_open, m_half;
    logic [7:0] m_idx, m_ldn;
    logic [7:0] m_glob [16];
    logic       m_en [NDEV];
    logic [15:0] m_base [NDEV];
    logic [7:0]  m_irq [NDEV];
    logic [7:0]  m_irqt [NDEV];

    always #2.5 clk = ~clk;

    sio_cfg_gate dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid_i(valid), .bus_write_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .cfg_open_o(open_o), .dev_en_o(en_o), .dev_base_o(base_o),
        .dev_irq_o(irq_o), .dev_irq_type_o(irqt_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mdl_reset();
        m_open = 0; m_half = 0; m_idx = 0; m_ldn = 0;
        for (int i = 0; i < 16; i++) m_glob[i] = 0;
        for (int d = 0; d < NDEV; d++) begin
            m_en[d] = 0; m_base[d] = 0; m_irq[d] = 0; m_irqt[d] = 0;
        end
    endtask

    task automatic mdl_write(input logic [11:0] a, input logic [7:0] d);
        if (a == IDXA) begin
            if (!m_open) begin
                if (d == 8'h87) begin
                    if (m_half) begin m_open = 1; m_half = 0; end
                    else m_half = 1;
                end else m_half = 0;
            end else if (d == 8'hAA) begin
                m_open = 0; m_idx = 0;
            end else m_idx = d;
        end else if (a == DATA && m_open) begin
            if (m_idx == 8'h07) m_ldn = d;
            else if (m_idx >= 8'h20 && m_idx <= 8'h2F) m_glob[m_idx - 8'h20] = d;
            else if (m_ldn < NDEV) begin
                case (m_idx)
                    8'h30: m_en[m_ldn] = d[0];
                    8'h60: m_base[m_ldn][15:8] = d;
                    8'h61: m_base[m_ldn][7:0] = d;
                    8'h70: m_irq[m_ldn] = d;
                    8'h71: m_irqt[m_ldn] = d;
                    default: ;
                endcase
            end
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [11:0] a);
        if (a == IDXA) return m_open ? m_idx : 8'hFF;
        if (a != DATA) return 8'h00;
        if (!m_open) return 8'hFF;
        if (m_idx == 8'h07) return m_ldn;
        if (m_idx >= 8'h20 && m_idx <= 8'h2F) return m_glob[m_idx - 8'h20];
        if (m_ldn >= NDEV) return 8'h00;
        case (m_idx)
            8'h30: return {7'b0, m_en[m_ldn]};
            8'h60: return m_base[m_ldn][15:8];
            8'h61: return m_base[m_ldn][7:0];
            8'h70: return m_irq[m_ldn];
            8'h71: return m_irqt[m_ldn];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string read_tag(input logic [11:0] a);
        if (a != IDXA && a != DATA) return "R1";
        if (!m_open) return "R5";
        if (a == IDXA) return "R6";
        if (m_idx == 8'h07 || m_ldn >= NDEV) return "R7";
        if (m_idx == 8'h30) return "R8";
        if (m_idx == 8'h60 || m_idx == 8'h61) return "R9";
        if (m_idx == 8'h70 || m_idx == 8'h71) return "R10";
        return "R12";
    endfunction

    task automatic check_outputs();
        chk("R2 open", {31'b0, open_o}, {31'b0, m_open});
        for (int d = 0; d < NDEV; d++) begin
            chk("R8 enable", {31'b0, en_o[d]}, {31'b0, m_en[d]});
            chk("R9 base", {16'b0, base_o[d*16 +: 16]}, {16'b0, m_base[d]});
            chk("R10 irq", {24'b0, irq_o[d*8 +: 8]}, {24'b0, m_irq[d]});
            chk("R10 irq type", {24'b0, irqt_o[d*8 +: 8]}, {24'b0, m_irqt[d]});
        end
    endtask

    // Write: driven at a falling edge, captured at the next rising edge.
    task automatic io_wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        valid = 1; wr = 1; addr = a; wdata = d;
        @(posedge clk);
        mdl_write(a, d);
        #1 valid = 0; wr = 0;
        @(negedge clk);
        check_outputs();
    endtask

    // Read: result is combinational, sampled inside the strobe cycle.
    task automatic io_rd(input logic [11:0] a, input string req);
        logic [7:0] e;
        @(negedge clk);
        valid = 1; wr = 0; addr = a; wdata = 8'h00;
        #1;
        e = exp_read(a);
        chk(req, {24'b0, rdata}, {24'b0, e});
        @(posedge clk);
        #1 valid = 0;
    endtask

    task automatic unlock();
        io_wr(IDXA, 8'h87); io_wr(IDXA, 8'h87);
    endtask

    task automatic set_reg(input logic [7:0] i, input logic [7:0] d);
        io_wr(IDXA, i); io_wr(DATA, d);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        mdl_reset();
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R11: reset state.
        check_outputs();
        io_rd(DATA, "R11 locked read after reset");
        io_rd(IDXA, "R5 index read locked");
        // R1: key written to a foreign address does not count.
        io_wr(12'h372, 8'h87); io_wr(IDXA, 8'h87);
        chk("R1 other address ignored", {31'b0, open_o}, 32'd0);
        io_wr(IDXA, 8'h00);
        // R3: interrupted key sequence.
        io_wr(IDXA, 8'h87); io_wr(IDXA, 8'h55); io_wr(IDXA, 8'h87);
        chk("R3 broken key stays locked", {31'b0, open_o}, 32'd0);
        io_wr(IDXA, 8'h00);
        // R5: locked data write ignored, then opened and inspected.
        io_wr(DATA, 8'h3C);
        // R2: two consecutive keys open the gate.
        unlock();
        chk("R2 gate opens", {31'b0, open_o}, 32'd1);
        io_rd(IDXA, "R11 index zero after unlock");
        io_rd(DATA, "R5 locked write left ldn at zero");
        // R6: index readback.
        io_wr(IDXA, 8'h61);
        io_rd(IDXA, "R6 index readback");
        // R7..R10: program device 2.
        set_reg(8'h07, 8'h02);
        io_rd(DATA, "R7 ldn readback");
        set_reg(8'h30, 8'hFF);
        io_rd(DATA, "R8 enable reads bit 0 only");
        set_reg(8'h60, 8'h03); set_reg(8'h61, 8'h38);
        set_reg(8'h70, 8'h0A); set_reg(8'h71, 8'h02);
        io_rd(DATA, "R10 irq type readback");
        chk("R9 base of device 2", {16'b0, base_o[2*16 +: 16]}, 32'h0338);
        // R7: out-of-range device number.
        set_reg(8'h07, 8'h09);
        set_reg(8'h30, 8'h01);
        io_rd(DATA, "R7 out-of-range bank reads zero");
        // R12: global register works with any device number.
        set_reg(8'h2F, 8'hC4);
        io_rd(DATA, "R12 global readback");
        set_reg(8'h55, 8'h77);
        io_rd(DATA, "R12 unimplemented index reads zero");
        // R4: exit locks; 0xAA not kept as index.
        io_wr(IDXA, 8'hAA);
        chk("R4 exit locks", {31'b0, open_o}, 32'd0);
        io_rd(DATA, "R5 read while locked");
        unlock();
        io_rd(IDXA, "R4 index cleared by lock");
        io_wr(IDXA, 8'h2F);
        io_rd(DATA, "R4 registers kept across lock");
        // Random phase.
        for (int n = 0; n < 3000; n++) begin
            int k;
            logic [7:0] v;
            k = $urandom_range(0, 11);
            case ($urandom_range(0, 11))
                0, 1: v = 8'h87;
                2:    v = 8'hAA;
                3:    v = 8'h07;
                4:    v = 8'h30;
                5:    v = 8'h60;
                6:    v = 8'h61;
                7:    v = 8'h70;
                8:    v = 8'h71;
                9:    v = 8'(8'h20 + $urandom_range(0, 15));
                default: v = 8'($urandom_range(0, 255));
            endcase
            if (m_idx == 8'h07 && k >= 4 && k <= 6) v = 8'($urandom_range(0, 5));
            if (k <= 3)       io_wr(IDXA, v);
            else if (k <= 6)  io_wr(DATA, v);
            else if (k <= 8)  io_rd(DATA, read_tag(DATA));
            else if (k == 9)  io_rd(IDXA, read_tag(IDXA));
            else if (k == 10) io_wr(12'h36F, v);
            else              io_rd(12'h372, read_tag(12'h372));
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule